// File: doc/BRIEF.md
# VLIW Packet Slot Assigner

This block places the instructions of one VLIW packet onto execution slots. A packet carries up to four entries and the slots are numbered from 3 (highest) down to 0. Per entry the caller supplies a legal-slot mask, a memory-class flag, a short-form (sub-instruction) flag and an end-of-loop flag, together with the number of valid entries. The block returns a slot number per entry and a flag telling whether the final placement is free of conflicts.

The work runs as a short multi-cycle pass behind a start/done handshake. A state machine steps through `ST_IDLE` → `ST_GREEDY` → `ST_MEMFIX` → `ST_SUBFIX` → `ST_FILL` → `ST_CHECK` → `ST_DONE`. `ST_IDLE` and `ST_DONE` leave on `start_i`, going to `ST_GREEDY` for a non-empty packet or straight to `ST_FILL` for an empty one. `ST_GREEDY` handles one entry per cycle in index order and moves on after the last valid entry. `ST_MEMFIX` and `ST_SUBFIX` each walk the entries from the last valid one down to index 0, one per cycle, then move on. `ST_FILL` and `ST_CHECK` take one cycle each, and `ST_DONE` holds the result until the next start. A start pulse seen in any other state is ignored.

Top module: `slot_assigner`

## Requirements
- R1: The greedy phase visits entries in index order with a candidate that begins at the top slot. Each entry takes the highest slot that is at or below the candidate and set in its mask. Mask bit s of entry i is `legal_mask_i[i*4+s]`. If no such slot exists, the entry takes slot 0.
- R2: After an entry takes slot s, the candidate becomes s-1 when s is above 0, and otherwise stays at 0. This allows several entries to land on slot 0.
- R3: Once the greedy phase ends, a scan from the last valid entry down to entry 0 moves the first memory-class entry it meets to slot 0 and every other memory-class entry to slot 1.
- R4: A second backward scan runs after the memory scan and uses its own first-seen flag. The last sub-instruction entry goes to slot 0 and every earlier sub-instruction entry goes to slot 1.
- R5: Suppose no valid non-end-of-loop entry sits on slot 0 while at least one valid entry sits on slot 1. Then the lowest-indexed entry on slot 1 is moved to slot 0.
- R6: End-of-loop entries do not count as occupying slot 0 in the R5 test, and they never take part in a conflict.
- R7: `valid_o` is 1 exactly when no two valid, non-end-of-loop entries end on the same slot.
- R8: Entries at index `count_i` or above are ignored and report slot 0. A count above four is treated as four. A count of 0 finishes with every slot at 0 and `valid_o` at 1.
- R9: `done_o` rises when the pass completes. From then until the next `start_i`, `done_o`, `valid_o` and `slot_o` are held steady even if the inputs change. A start pulse during a pass is ignored.
- R10: After reset, `done_o` and `valid_o` are 0 and all slot fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a pass and captures all packet inputs |
| count_i | input | 3 | Number of valid entries |
| legal_mask_i | input | 16 | Legal-slot mask, 4 bits per entry, entry i at [4i+3:4i] |
| mem_i | input | 4 | Memory-class flag per entry |
| sub_i | input | 4 | Sub-instruction flag per entry |
| eol_i | input | 4 | End-of-loop flag per entry |
| done_o | output | 1 | Result available and held |
| valid_o | output | 1 | Placement has no conflict |
| slot_o | output | 8 | Slot per entry, entry i at [2i+1:2i] |

## Verification
The bench builds the block with its default parameters, four entries and four slots. This is the smallest size at which every phase can show its effect. A full packet reaches the greedy share-slot-0 case, the two backward scans leave one entry at 0 and the rest at 1, the fill step has a slot 1 to borrow from, and a pair of entries can collide. With four entries, a count above the entry limit also fits in the count port, so clamping is reachable.

// File: rtl/slot_assigner_pkg.sv
package slot_assigner_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_GREEDY = 3'd1,
        ST_MEMFIX = 3'd2,
        ST_SUBFIX = 3'd3,
        ST_FILL   = 3'd4,
        ST_CHECK  = 3'd5,
        ST_DONE   = 3'd6
    } sa_state_e;

endpackage

// File: rtl/slot_greedy_pick.sv
// Chooses the highest legal slot not above the running candidate.
module slot_greedy_pick #(
    parameter int NUM_SLOT = 4,
    localparam int SLOT_W  = (NUM_SLOT > 1) ? $clog2(NUM_SLOT) : 1
) (
    input  logic [NUM_SLOT-1:0] mask_i,
    input  logic [SLOT_W-1:0]   cand_i,
    output logic [SLOT_W-1:0]   pick_o,
    output logic [SLOT_W-1:0]   next_cand_o
);

    always_comb begin
        pick_o = '0;
        // ascending walk: the last hit is the highest legal slot
        for (int s = 0; s < NUM_SLOT; s++) begin
            if (mask_i[s] && (SLOT_W'(s) <= cand_i)) begin
                pick_o = SLOT_W'(s);
            end
        end
        next_cand_o = (pick_o != '0) ? pick_o - SLOT_W'(1) : '0;
    end

endmodule

// File: rtl/slot_fill_pick.sv
// Decides whether slot 0 must borrow the lowest-indexed slot-1 entry.
module slot_fill_pick #(
    parameter int NUM_INSN = 4,
    parameter int SLOT_W   = 2,
    localparam int IDX_W   = (NUM_INSN > 1) ? $clog2(NUM_INSN) : 1
) (
    input  logic [NUM_INSN-1:0][SLOT_W-1:0] slots_i,
    input  logic [NUM_INSN-1:0]             vld_i,
    input  logic [NUM_INSN-1:0]             eol_i,
    output logic                            move_en_o,
    output logic [IDX_W-1:0]                move_idx_o
);

    logic occ0;
    logic seen1;

    always_comb begin
        occ0       = 1'b0;
        seen1      = 1'b0;
        move_idx_o = '0;
        // descending walk: the last hit on slot 1 is the lowest index
        for (int i = NUM_INSN - 1; i >= 0; i--) begin
            if (vld_i[i] && !eol_i[i] && (slots_i[i] == '0)) begin
                occ0 = 1'b1;
            end
            if (vld_i[i] && (slots_i[i] == SLOT_W'(1))) begin
                seen1      = 1'b1;
                move_idx_o = IDX_W'(i);
            end
        end
        move_en_o = !occ0 && seen1;
    end

endmodule

// File: rtl/slot_conflict.sv
// Flags any pair of live (valid, non-end-of-loop) entries on one slot.
module slot_conflict #(
    parameter int NUM_INSN = 4,
    parameter int SLOT_W   = 2
) (
    input  logic [NUM_INSN-1:0][SLOT_W-1:0] slots_i,
    input  logic [NUM_INSN-1:0]             vld_i,
    input  logic [NUM_INSN-1:0]             eol_i,
    output logic                            clash_o
);

    logic [NUM_INSN-1:0] live;

    always_comb begin
        live    = vld_i & ~eol_i;
        clash_o = 1'b0;
        for (int a = 0; a < NUM_INSN; a++) begin
            for (int b = a + 1; b < NUM_INSN; b++) begin
                if (live[a] && live[b] && (slots_i[a] == slots_i[b])) begin
                    clash_o = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/slot_assigner.sv
module slot_assigner
    import slot_assigner_pkg::*;
#(
    parameter int NUM_INSN = 4,
    parameter int NUM_SLOT = 4,
    localparam int SLOT_W  = (NUM_SLOT > 1) ? $clog2(NUM_SLOT) : 1,
    localparam int IDX_W   = (NUM_INSN > 1) ? $clog2(NUM_INSN) : 1,
    localparam int CNT_W   = $clog2(NUM_INSN + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_i,
    input  logic [CNT_W-1:0]             count_i,
    input  logic [NUM_INSN*NUM_SLOT-1:0] legal_mask_i,
    input  logic [NUM_INSN-1:0]          mem_i,
    input  logic [NUM_INSN-1:0]          sub_i,
    input  logic [NUM_INSN-1:0]          eol_i,
    output logic                         done_o,
    output logic                         valid_o,
    output logic [NUM_INSN*SLOT_W-1:0]   slot_o
);

    sa_state_e state_q, state_d;

    logic [NUM_INSN-1:0][NUM_SLOT-1:0] legal_q;
    logic [NUM_INSN-1:0][SLOT_W-1:0]   slot_q;
    logic [NUM_INSN-1:0]               mem_q, sub_q, eol_q;
    logic [CNT_W-1:0]                  cnt_q;
    logic [SLOT_W-1:0]                 cand_q;
    logic [IDX_W-1:0]                  idx_q;
    logic                              seen_q;
    logic                              valid_q;

    logic [CNT_W-1:0]    cnt_in;
    logic [NUM_INSN-1:0] vld;
    logic [IDX_W-1:0]    last_idx;
    logic                launch;

    logic [SLOT_W-1:0] pick, next_cand;
    logic              move_en;
    logic [IDX_W-1:0]  move_idx;
    logic              clash;

    // ---------------------------------------------------------------
    // Derived control
    // ---------------------------------------------------------------
    assign cnt_in   = (count_i > CNT_W'(NUM_INSN)) ? CNT_W'(NUM_INSN) : count_i;
    assign last_idx = IDX_W'(cnt_q - CNT_W'(1));
    assign launch   = start_i && ((state_q == ST_IDLE) || (state_q == ST_DONE));

    always_comb begin
        for (int i = 0; i < NUM_INSN; i++) begin
            vld[i] = (CNT_W'(i) < cnt_q);
        end
    end

    // ---------------------------------------------------------------
    // Sub-blocks
    // ---------------------------------------------------------------
    slot_greedy_pick #(.NUM_SLOT(NUM_SLOT)) u_pick (
        .mask_i      (legal_q[idx_q]),
        .cand_i      (cand_q),
        .pick_o      (pick),
        .next_cand_o (next_cand)
    );

    slot_fill_pick #(.NUM_INSN(NUM_INSN), .SLOT_W(SLOT_W)) u_fill (
        .slots_i    (slot_q),
        .vld_i      (vld),
        .eol_i      (eol_q),
        .move_en_o  (move_en),
        .move_idx_o (move_idx)
    );

    slot_conflict #(.NUM_INSN(NUM_INSN), .SLOT_W(SLOT_W)) u_clash (
        .slots_i (slot_q),
        .vld_i   (vld),
        .eol_i   (eol_q),
        .clash_o (clash)
    );

    // ---------------------------------------------------------------
    // State register
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------------------------------------------------------
    // Next-state logic
    // ---------------------------------------------------------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    state_d = (cnt_in == '0) ? ST_FILL : ST_GREEDY;
                end
            end
            ST_GREEDY: if (idx_q == last_idx) state_d = ST_MEMFIX;
            ST_MEMFIX: if (idx_q == '0)       state_d = ST_SUBFIX;
            ST_SUBFIX: if (idx_q == '0)       state_d = ST_FILL;
            ST_FILL:   state_d = ST_CHECK;
            ST_CHECK:  state_d = ST_DONE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // ---------------------------------------------------------------
    // Datapath and outputs
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            legal_q <= '0;
            slot_q  <= '0;
            mem_q   <= '0;
            sub_q   <= '0;
            eol_q   <= '0;
            cnt_q   <= '0;
            cand_q  <= '0;
            idx_q   <= '0;
            seen_q  <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (start_i) begin
                        legal_q <= legal_mask_i;
                        mem_q   <= mem_i;
                        sub_q   <= sub_i;
                        eol_q   <= eol_i;
                        cnt_q   <= cnt_in;
                        slot_q  <= '0;
                        cand_q  <= SLOT_W'(NUM_SLOT - 1);
                        idx_q   <= '0;
                        seen_q  <= 1'b0;
                        valid_q <= 1'b0;
                    end
                end
                ST_GREEDY: begin
                    slot_q[idx_q] <= pick;
                    cand_q        <= next_cand;
                    if (idx_q == last_idx) begin
                        seen_q <= 1'b0;
                    end else begin
                        idx_q <= idx_q + IDX_W'(1);
                    end
                end
                ST_MEMFIX: begin
                    if (mem_q[idx_q] && vld[idx_q]) begin
                        slot_q[idx_q] <= seen_q ? SLOT_W'(1) : '0;
                        seen_q        <= 1'b1;
                    end
                    if (idx_q == '0) begin
                        idx_q  <= last_idx;
                        seen_q <= 1'b0;
                    end else begin
                        idx_q <= idx_q - IDX_W'(1);
                    end
                end
                ST_SUBFIX: begin
                    if (sub_q[idx_q] && vld[idx_q]) begin
                        slot_q[idx_q] <= seen_q ? SLOT_W'(1) : '0;
                        seen_q        <= 1'b1;
                    end
                    if (idx_q != '0) begin
                        idx_q <= idx_q - IDX_W'(1);
                    end
                end
                ST_FILL: begin
                    if (move_en) begin
                        slot_q[move_idx] <= '0;
                    end
                end
                ST_CHECK: begin
                    valid_q <= !clash;
                end
                default: ;
            endcase
        end
    end

    assign done_o  = (state_q == ST_DONE);
    assign valid_o = valid_q;
    assign slot_o  = slot_q;

    // ---------------------------------------------------------------
    // Checks
    // ---------------------------------------------------------------
    logic [NUM_SLOT-1:0] live_occ;
    logic [NUM_INSN-1:0] live;
    logic                any_on0, any_on1, low_ok, beyond_ok;

    always_comb begin
        live      = vld & ~eol_q;
        live_occ  = '0;
        any_on0   = 1'b0;
        any_on1   = 1'b0;
        low_ok    = 1'b1;
        beyond_ok = 1'b1;
        for (int i = 0; i < NUM_INSN; i++) begin
            if (live[i]) live_occ[slot_q[i]] = 1'b1;
            if (vld[i] && slot_q[i] == '0)         any_on0 = 1'b1;
            if (vld[i] && slot_q[i] == SLOT_W'(1)) any_on1 = 1'b1;
            if (vld[i] && (mem_q[i] || sub_q[i]) && slot_q[i] > SLOT_W'(1)) low_ok = 1'b0;
            if (!vld[i] && slot_q[i] != '0) beyond_ok = 1'b0;
        end
    end

    assert_cand_falls_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GREEDY) |=> (cand_q <= $past(cand_q)));

    assert_mem_sub_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> low_ok);

    assert_slot0_filled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !(any_on1 && !any_on0));

    assert_valid_distinct_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && valid_o) |-> ($countones(live_occ) == $countones(live)));

    assert_beyond_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> beyond_ok);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(slot_o) && $stable(valid_o)));

endmodule

// File: tb/sim_slot_assigner.sv
module sim_slot_assigner;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  count_i = '0;
    logic [15:0] legal_mask_i = '0;
    logic [3:0]  mem_i = '0;
    logic [3:0]  sub_i = '0;
    logic [3:0]  eol_i = '0;
    logic        done_o;
    logic        valid_o;
    logic [7:0]  slot_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    slot_assigner u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .count_i      (count_i),
        .legal_mask_i (legal_mask_i),
        .mem_i        (mem_i),
        .sub_i        (sub_i),
        .eol_i        (eol_i),
        .done_o       (done_o),
        .valid_o      (valid_o),
        .slot_o       (slot_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load(input logic [2:0] c, input logic [15:0] m,
                        input logic [3:0] me, input logic [3:0] su, input logic [3:0] eo);
        count_i = c; legal_mask_i = m; mem_i = me; sub_i = su; eol_i = eo;
    endtask

    task automatic pulse_start;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!done_o && n < 200) begin
            @(negedge clk); n++;
        end
        chk(done_o, tag, {7'd0, done_o}, 8'd1);
    endtask

    task automatic run_case(input string tag, input logic [2:0] c, input logic [15:0] m,
                            input logic [3:0] me, input logic [3:0] su, input logic [3:0] eo,
                            input logic [7:0] exp_slot, input bit exp_valid);
        load(c, m, me, su, eo);
        pulse_start();
        wait_done(tag);
        chk(slot_o == exp_slot, tag, slot_o, exp_slot);
        chk(valid_o == exp_valid, tag, {7'd0, valid_o}, {7'd0, exp_valid});
    endtask

    task automatic t_reset;
        chk(done_o == 1'b0, "R10 done", {7'd0, done_o}, 8'd0);
        chk(valid_o == 1'b0, "R10 valid", {7'd0, valid_o}, 8'd0);
        chk(slot_o == 8'h00, "R10 slots", slot_o, 8'h00);
    endtask

    task automatic t_greedy;
        run_case("R1 all legal", 3'd4, 16'hFFFF, 4'h0, 4'h0, 4'h0, 8'h1B, 1'b1);
        run_case("R1 skip down", 3'd3, 16'h0FF4, 4'h0, 4'h0, 4'h0, 8'h06, 1'b1);
        run_case("R1 none legal", 3'd2, 16'h0088, 4'h0, 4'h0, 4'h0, 8'h03, 1'b1);
    endtask

    task automatic t_share0;
        // R2 and R7: both entries fall to slot 0 and collide
        run_case("R2 R7 share0", 3'd2, 16'h0011, 4'h0, 4'h0, 4'h0, 8'h00, 1'b0);
    endtask

    task automatic t_memfix;
        run_case("R3 mem scan", 3'd3, 16'hFFFF, 4'b0101, 4'h0, 4'h0, 8'h09, 1'b1);
    endtask

    task automatic t_subfix;
        run_case("R4 sub scan", 3'd2, 16'hFFFF, 4'h0, 4'b0011, 4'h0, 8'h01, 1'b1);
        run_case("R4 after mem", 3'd3, 16'hFFFF, 4'b0001, 4'b0010, 4'h0, 8'h10, 1'b0);
    endtask

    task automatic t_fill;
        run_case("R5 fill", 3'd2, 16'h0028, 4'h0, 4'h0, 4'h0, 8'h03, 1'b1);
        run_case("R5 R6 lowest", 3'd3, 16'hFFFF, 4'b0111, 4'h0, 4'b0100, 8'h04, 1'b1);
    endtask

    task automatic t_eol;
        run_case("R6 eol share", 3'd2, 16'h0011, 4'h0, 4'h0, 4'b0010, 8'h00, 1'b1);
    endtask

    task automatic t_count;
        run_case("R8 beyond count", 3'd2, 16'hFFFF, 4'b1100, 4'b1100, 4'h0, 8'h0B, 1'b1);
        run_case("R8 clamp", 3'd7, 16'hFFFF, 4'h0, 4'h0, 4'h0, 8'h1B, 1'b1);
        run_case("R8 empty", 3'd0, 16'hFFFF, 4'hF, 4'hF, 4'h0, 8'h00, 1'b1);
    endtask

    task automatic t_hold;
        run_case("R9 base", 3'd4, 16'hFFFF, 4'h0, 4'h0, 4'h0, 8'h1B, 1'b1);
        load(3'd1, 16'h1111, 4'hF, 4'hF, 4'hF);
        repeat (6) @(negedge clk);
        chk(done_o == 1'b1, "R9 done held", {7'd0, done_o}, 8'd1);
        chk(slot_o == 8'h1B, "R9 slots held", slot_o, 8'h1B);
        chk(valid_o == 1'b1, "R9 valid held", {7'd0, valid_o}, 8'd1);
        // restart, then a second start mid-pass must be ignored
        load(3'd4, 16'hFFFF, 4'h0, 4'h0, 4'h0);
        pulse_start();
        load(3'd1, 16'h0001, 4'h0, 4'h0, 4'h0);
        @(negedge clk);
        chk(done_o == 1'b0, "R9 busy", {7'd0, done_o}, 8'd0);
        pulse_start();
        wait_done("R9 busy start");
        chk(slot_o == 8'h1B, "R9 busy start ignored", slot_o, 8'h1B);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_greedy();
        t_share0();
        t_memfix();
        t_subfix();
        t_fill();
        t_eol();
        t_count();
        t_hold();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule